// File: doc/BRIEF.md
# Planar Raster Logic Operation Unit

This block applies one raster logic operation to a single byte address in a video memory that is split into up to four bit-planes. Each plane contributes one bit of every pixel's colour. For each plane that takes part, the unit reads the stored byte, forms an operand from the selected operation and that plane's colour bit or tile byte, and combines old and operand under a write mask. Mask bits set to 1 keep the stored pixels. An optional per-pixel compare status word can then decide, pixel by pixel, whether the new value or the stored value is written back.

Configuration is held in eight-bit registers loaded through a small select/data write port. A pulse on `start` launches one operation at the address on `addr`. The unit spends one cycle in a read phase and one cycle in a write phase, and raises `done` for one cycle afterwards. The memory is reached through simple per-plane byte ports that return read data one cycle after the read strobe. The compare status word and a per-plane page-lock mask come from neighbouring logic.

Top module: `plane_rop_unit`

## Requirements
- R1: Command register bit 7 enables the unit. While that bit is 0, a `start` pulse causes no memory access, `busy` stays low and no `done` pulse follows.
- R2: Command bits 2:0 select the operation: 0 pixel set, 1 reserved, 2 OR, 3 AND, 4 XOR, 5 NOT, 6 tile paint, 7 blank. Every operation writes (old & mask) | (operand & ~mask).
- R3: For OR the operand is 0xFF when the plane's colour bit is 1 and the old byte when it is 0. For AND the operand is the old byte when the colour bit is 1 and 0x00 when it is 0.
- R4: For XOR the operand is the old byte XOR the colour bit copied to all eight bits. For NOT it is the inverted old byte. For tile paint it is that plane's tile register.
- R5: Pixel set uses the colour bit copied to all eight bits as operand. Blank writes old & mask. The reserved code performs the read phase but writes no plane.
- R6: A plane whose bit is set in the plane-disable register is neither read nor written.
- R7: A plane whose bit is set in the `page_lock` input is neither read nor written.
- R8: With command bit 6 set and bit 5 clear, the written byte is (old & ~status) | (result & status).
- R9: With command bits 6 and 5 both set, the written byte is (old & status) | (result & ~status).
- R10: A `start` accepted at a clock edge gives a read strobe in the next cycle and the write strobe in the cycle after that. `done` is then high for exactly one cycle, and `busy` is high during the read and write cycles. A `start` while busy is ignored.
- R11: After reset the command, colour, mask, disable and tile registers are zero, and `busy`, `done` and all strobes are low.
- R12: Register select codes: 0 command, 1 colour (bit p for plane p), 2 mask, 3 plane-disable (bit p for plane p), 4+p tile byte of plane p.

Ports table: the `cfg_sel` width shown is for the default of four planes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 8 | Register write data |
| page_lock | input | 4 | Per-plane access lock |
| cmp_status | input | 8 | Per-pixel compare result for gated writes |
| start | input | 1 | Launch one operation |
| addr | input | 14 | Byte address of the operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 14 | Byte address presented to all planes |
| mem_rd_en | output | 4 | Per-plane read strobe |
| mem_rdata | input | 32 | Per-plane read data, plane p in bits 8p+7:8p |
| mem_wr_en | output | 4 | Per-plane write strobe |
| mem_wdata | output | 32 | Per-plane write data, plane p in bits 8p+7:8p |

## Verification
A wrong operand or merge term shows up as a wrong byte in one plane's memory word two cycles after `start`, which is when the write strobe lands. The bench compares every plane's word after each operation, over all eight operation codes, all three gating modes and random data. A sequencer fault shows up as a missing or displaced strobe, or as a `done` that is absent or lasts too long, within the four cycles after `start`. A fault in the disable or lock handling shows up as a changed word in a plane that had to stay untouched.

// File: rtl/rop_pkg.sv
// Package: shared encodings of the planar raster logic operation unit.
// Assumes an eight-bit command register with the field positions below.
package rop_pkg;

    typedef enum logic [2:0] {
        OP_PSET  = 3'd0,
        OP_RSVD  = 3'd1,
        OP_OR    = 3'd2,
        OP_AND   = 3'd3,
        OP_XOR   = 3'd4,
        OP_NOT   = 3'd5,
        OP_TILE  = 3'd6,
        OP_BLANK = 3'd7
    } rop_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } rop_state_e;

    localparam int CMD_EN_BIT   = 7;
    localparam int CMD_GATE_BIT = 6;
    localparam int CMD_NAND_BIT = 5;

    localparam int SEL_CMD   = 0;
    localparam int SEL_COLOR = 1;
    localparam int SEL_MASK  = 2;
    localparam int SEL_DIS   = 3;
    localparam int SEL_TILE0 = 4;

endpackage

// File: rtl/rop_regs.sv
// Module: configuration register file of the raster unit.
// Holds the command, colour, mask, plane-disable and per-plane tile registers.
// Assumes one write per cycle through a select code; all registers clear on reset.
module rop_regs #(
    parameter int NP    = 4,
    parameter int DW    = 8,
    parameter int SEL_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [SEL_W-1:0]     sel,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        cmd_q,
    output logic [NP-1:0]        color_q,
    output logic [DW-1:0]        mask_q,
    output logic [NP-1:0]        dis_q,
    output logic [NP*DW-1:0]     tile_q
);
    import rop_pkg::*;

    // Purpose: load the shared control registers on a matching select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            color_q <= '0;
            mask_q  <= '0;
            dis_q   <= '0;
        end else if (we) begin
            if (sel == SEL_W'(SEL_CMD))   cmd_q   <= wdata;
            if (sel == SEL_W'(SEL_COLOR)) color_q <= wdata[NP-1:0];
            if (sel == SEL_W'(SEL_MASK))  mask_q  <= wdata;
            if (sel == SEL_W'(SEL_DIS))   dis_q   <= wdata[NP-1:0];
        end
    end

    genvar p;
    generate
        for (p = 0; p < NP; p++) begin : g_tile
            // Purpose: load the tile byte of plane p.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tile_q[p*DW +: DW] <= '0;
                end else if (we && sel == SEL_W'(SEL_TILE0 + p)) begin
                    tile_q[p*DW +: DW] <= wdata;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rop_plane_alu.sv
// Module: per-plane combinational datapath.
// Forms the operand from the operation, merges it under the mask and applies
// optional compare gating. Assumes old_byte is the byte just read from the plane.
module rop_plane_alu #(
    parameter int DW = 8
) (
    input  rop_pkg::rop_op_e op,
    input  logic [DW-1:0]    old_byte,
    input  logic             color_bit,
    input  logic [DW-1:0]    tile_byte,
    input  logic [DW-1:0]    mask,
    input  logic             gate_en,
    input  logic             gate_nand,
    input  logic [DW-1:0]    status,
    output logic [DW-1:0]    new_byte
);
    import rop_pkg::*;

    logic [DW-1:0] color_fill;
    logic [DW-1:0] operand;
    logic [DW-1:0] merged;
    logic [DW-1:0] take_new;

    assign color_fill = {DW{color_bit}};

    // Purpose: choose the operand for the selected operation.
    always_comb begin
        unique case (op)
            OP_PSET:  operand = color_fill;
            OP_OR:    operand = color_bit ? '1 : old_byte;
            OP_AND:   operand = color_bit ? old_byte : '0;
            OP_XOR:   operand = old_byte ^ color_fill;
            OP_NOT:   operand = ~old_byte;
            OP_TILE:  operand = tile_byte;
            default:  operand = '0;
        endcase
    end

    // Purpose: keep masked pixels, then pick old or new per pixel under gating.
    always_comb begin
        merged   = (old_byte & mask) | (operand & ~mask);
        take_new = !gate_en ? '1 : (gate_nand ? ~status : status);
        new_byte = (old_byte & ~take_new) | (merged & take_new);
    end

endmodule

// File: rtl/rop_seq.sv
// Module: read/write phase sequencer.
// One accepted go gives one read cycle, one write cycle and a one-cycle done.
// Assumes go is only honoured while idle.
module rop_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy,
    output logic in_read,
    output logic in_write,
    output logic done
);
    import rop_pkg::*;

    rop_state_e state_q;

    // Purpose: step through idle, read and write phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (go) state_q <= ST_READ;
                ST_READ:  state_q <= ST_WRITE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: pulse done in the cycle after the write phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= (state_q == ST_WRITE);
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign in_read  = (state_q == ST_READ);
    assign in_write = (state_q == ST_WRITE);

endmodule

// File: rtl/plane_rop_unit.sv
// Module: planar raster logic operation unit (top).
// Performs one read-modify-write at a byte address across NP planes.
// Assumes memory read data arrives one cycle after the read strobe.
module plane_rop_unit #(
    parameter int NP    = 4,
    parameter int DW    = 8,
    parameter int AW    = 14,
    parameter int SEL_W = $clog2(NP + 4)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [DW-1:0]       cfg_wdata,
    input  logic [NP-1:0]       page_lock,
    input  logic [DW-1:0]       cmp_status,
    input  logic                start,
    input  logic [AW-1:0]       addr,
    output logic                busy,
    output logic                done,
    output logic [AW-1:0]       mem_addr,
    output logic [NP-1:0]       mem_rd_en,
    input  logic [NP*DW-1:0]    mem_rdata,
    output logic [NP-1:0]       mem_wr_en,
    output logic [NP*DW-1:0]    mem_wdata
);
    import rop_pkg::*;

    logic [DW-1:0]    cmd_q;
    logic [NP-1:0]    color_q;
    logic [DW-1:0]    mask_q;
    logic [NP-1:0]    dis_q;
    logic [NP*DW-1:0] tile_q;
    logic [AW-1:0]    addr_q;
    logic             go;
    logic             in_read;
    logic             in_write;
    rop_op_e          op;
    logic             unused_cmd_bits;

    assign op              = rop_op_e'(cmd_q[2:0]);
    assign go              = start && cmd_q[CMD_EN_BIT] && !busy;
    assign unused_cmd_bits = ^cmd_q[4:3];
    assign mem_addr        = addr_q;

    rop_regs #(.NP(NP), .DW(DW), .SEL_W(SEL_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .cmd_q   (cmd_q),
        .color_q (color_q),
        .mask_q  (mask_q),
        .dis_q   (dis_q),
        .tile_q  (tile_q)
    );

    rop_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .busy     (busy),
        .in_read  (in_read),
        .in_write (in_write),
        .done     (done)
    );

    // Purpose: hold the operation address for both phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (go) begin
            addr_q <= addr;
        end
    end

    genvar p;
    generate
        for (p = 0; p < NP; p++) begin : g_plane
            logic touch;
            assign touch        = !dis_q[p] && !page_lock[p];
            assign mem_rd_en[p] = in_read && touch;
            assign mem_wr_en[p] = in_write && touch && (op != OP_RSVD);

            rop_plane_alu #(.DW(DW)) u_alu (
                .op        (op),
                .old_byte  (mem_rdata[p*DW +: DW]),
                .color_bit (color_q[p]),
                .tile_byte (tile_q[p*DW +: DW]),
                .mask      (mask_q),
                .gate_en   (cmd_q[CMD_GATE_BIT]),
                .gate_nand (cmd_q[CMD_NAND_BIT]),
                .status    (cmp_status),
                .new_byte  (mem_wdata[p*DW +: DW])
            );
        end
    endgenerate

endmodule

// File: rtl/rop_unit_checker.sv
// Module: protocol checker for plane_rop_unit, attached by bind.
// Assumes it observes the top's ports plus its disable and enable state.
module rop_unit_checker #(
    parameter int NP = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [NP-1:0] mem_rd_en,
    input logic [NP-1:0] mem_wr_en,
    input logic [NP-1:0] page_lock,
    input logic [NP-1:0] dis,
    input logic          cmd_en
);

    a_r1_off_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !cmd_en && !busy) |=> !busy);

    a_r6_disabled_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd_en | mem_wr_en) & dis) == '0);

    a_r7_locked_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd_en | mem_wr_en) & page_lock) == '0);

    a_r10_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_rd_en) |=> !(|mem_rd_en));

    a_r10_write_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_wr_en) |-> busy);

    a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

endmodule

bind plane_rop_unit rop_unit_checker #(.NP(NP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .page_lock (page_lock),
    .dis       (dis_q),
    .cmd_en    (cmd_q[7])
);

// File: tb/tb_plane_rop_unit.sv
module tb_plane_rop_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int DW = 8;
    localparam int AW = 14;
    localparam int SW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [SW-1:0]     cfg_sel = '0;
    logic [DW-1:0]     cfg_wdata = '0;
    logic [NP-1:0]     page_lock = '0;
    logic [DW-1:0]     cmp_status = '0;
    logic              start = 1'b0;
    logic [AW-1:0]     addr = '0;
    logic              busy, done;
    logic [AW-1:0]     mem_addr;
    logic [NP-1:0]     mem_rd_en, mem_wr_en;
    logic [NP*DW-1:0]  mem_rdata, mem_wdata;

    logic [DW-1:0] bmem [NP][16];
    logic [DW-1:0] rdq  [NP];

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    plane_rop_unit #(.NP(NP), .DW(DW), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .page_lock(page_lock), .cmp_status(cmp_status),
        .start(start), .addr(addr), .busy(busy), .done(done),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata)
    );

    // Memory model: one-cycle read latency, write on strobe.
    always @(posedge clk) begin
        for (int p = 0; p < NP; p++) begin
            if (mem_rd_en[p]) rdq[p] <= bmem[p][mem_addr[3:0]];
            if (mem_wr_en[p]) bmem[p][mem_addr[3:0]] <= mem_wdata[p*DW +: DW];
        end
    end
    always_comb begin
        for (int p = 0; p < NP; p++) mem_rdata[p*DW +: DW] = rdq[p];
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input int sel, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = SW'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Bench model of one byte, computed pixel by pixel.
    function automatic logic [7:0] model(input int op, input logic [7:0] old,
        input logic c, input logic [7:0] tile, input logic [7:0] m,
        input logic gate, input logic nand_pol, input logic [7:0] st);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) begin
            logic o, ob, nb;
            o = old[b];
            case (op)
                0: ob = c;
                2: ob = o | c;
                3: ob = o & c;
                4: ob = o ^ c;
                5: ob = !o;
                6: ob = tile[b];
                default: ob = 1'b0;
            endcase
            nb = m[b] ? o : ob;
            if (gate && (nand_pol ? st[b] : !st[b])) nb = o;
            r[b] = nb;
        end
        return r;
    endfunction

    // Launch one operation and check its strobe timing (R10).
    task automatic run_op(input logic [3:0] a, input logic [NP-1:0] exp_rd,
                          input logic [NP-1:0] exp_wr);
        @(negedge clk);
        start = 1'b1; addr = AW'(a);
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R10 busy in read", int'(busy), 1);
        chk(mem_rd_en === exp_rd, "R6/R7/R10 read strobes", int'(mem_rd_en), int'(exp_rd));
        @(negedge clk);
        chk(mem_wr_en === exp_wr, "R5/R6/R7/R10 write strobes", int'(mem_wr_en), int'(exp_wr));
        @(negedge clk);
        chk(done === 1'b1 && busy === 1'b0, "R10 done pulse", int'(done), 1);
        @(negedge clk);
        chk(done === 1'b0, "R10 done one cycle", int'(done), 0);
    endtask

    initial begin
        logic [7:0] oldv [NP];
        logic [7:0] tilev [NP];
        logic [7:0] exp_b;
        for (int p = 0; p < NP; p++)
            for (int i = 0; i < 16; i++) bmem[p][i] <= 8'($urandom);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: idle outputs after reset
        chk(busy === 1'b0, "R11 busy", int'(busy), 0);
        chk(done === 1'b0, "R11 done", int'(done), 0);
        chk(mem_rd_en === '0, "R11 rd_en", int'(mem_rd_en), 0);
        chk(mem_wr_en === '0, "R11 wr_en", int'(mem_wr_en), 0);

        // R11: tile paint right after reset writes zero to every plane (zero mask, tiles, disable)
        for (int p = 0; p < NP; p++) bmem[p][3] <= 8'h5A + 8'(p);
        cfg(0, 8'h86);
        run_op(4'd3, 4'hF, 4'hF);
        for (int p = 0; p < NP; p++)
            chk(bmem[p][3] === 8'h00, "R11 registers cleared", int'(bmem[p][3]), 0);

        // R1: disabled unit ignores start
        cfg(0, 8'h06);
        for (int p = 0; p < NP; p++) bmem[p][5] <= 8'hC3;
        @(negedge clk);
        start = 1'b1; addr = AW'(5);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk(busy === 1'b0 && done === 1'b0 && mem_rd_en === '0 && mem_wr_en === '0,
                "R1 no activity when off", int'({busy, done, mem_rd_en, mem_wr_en}), 0);
            @(negedge clk);
        end
        for (int p = 0; p < NP; p++)
            chk(bmem[p][5] === 8'hC3, "R1 memory unchanged", int'(bmem[p][5]), 8'hC3);

        // R2-R9, R12: sweep all operations and gating modes with random data
        for (int op = 0; op < 8; op++) begin
            for (int g = 0; g < 3; g++) begin
                for (int t = 0; t < 6; t++) begin
                    logic [3:0] a, col, dis, lock;
                    logic [7:0] m, st;
                    logic gate, np;
                    logic [NP-1:0] er, ew;
                    a = 4'(t + op);
                    col = 4'($urandom); m = 8'($urandom); st = 8'($urandom);
                    dis = (t < 2) ? 4'h0 : 4'($urandom);
                    lock = (t < 3) ? 4'h0 : 4'($urandom);
                    gate = (g != 0); np = (g == 2);
                    for (int p = 0; p < NP; p++) begin
                        oldv[p] = 8'($urandom);
                        tilev[p] = 8'($urandom);
                        bmem[p][a] <= oldv[p];
                        cfg(4 + p, tilev[p]);
                    end
                    cfg(1, {4'h0, col});
                    cfg(2, m);
                    cfg(3, {4'h0, dis});
                    cfg(0, 8'h80 | (gate ? 8'h40 : 8'h00) | (np ? 8'h20 : 8'h00) | 8'(op));
                    page_lock = lock; cmp_status = st;
                    er = ~dis & ~lock;
                    ew = (op == 1) ? 4'h0 : er;
                    run_op(a, er, ew);
                    for (int p = 0; p < NP; p++) begin
                        if (ew[p]) exp_b = model(op, oldv[p], col[p], tilev[p], m, gate, np, st);
                        else       exp_b = oldv[p];
                        chk(bmem[p][a] === exp_b,
                            (op == 1) ? "R5 reserved no write" :
                            (!er[p]) ? "R6/R7 plane untouched" :
                            (g == 1) ? "R8 gated write" :
                            (g == 2) ? "R9 nand gated write" :
                            (op == 2 || op == 3) ? "R3 or/and result" :
                            (op >= 4 && op <= 6) ? "R4 xor/not/tile result" :
                            "R2/R5/R12 pset/blank result",
                            int'(bmem[p][a]), int'(exp_b));
                    end
                end
            end
        end
        page_lock = '0;

        // R10: start while busy is ignored (one read strobe only, one done)
        cfg(3, 8'h00);
        cfg(0, 8'h85);
        @(negedge clk);
        start = 1'b1; addr = AW'(2);
        @(negedge clk);
        chk(mem_rd_en === 4'hF, "R10 read phase", int'(mem_rd_en), 15);
        @(negedge clk);
        chk(mem_rd_en === 4'h0 && mem_wr_en === 4'hF, "R10 start ignored while busy",
            int'({mem_rd_en, mem_wr_en}), 15);
        start = 1'b0;
        @(negedge clk);
        chk(done === 1'b1, "R10 done after write", int'(done), 1);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R10 back to idle", int'({done, busy}), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule